// File: doc/BRIEF.md
# Windowed Power Sample Averager

This block watches a pair of measurement codes, one for current and one for voltage, that some outside controller refreshes on a fixed period. Each refresh has an invalid stretch and then a valid stretch, and the two are told apart by a single flag. The block takes exactly one sample per refresh, on the clock edge where the flag is first seen high after having been low. It multiplies the two integer codes to get a power code. With a current step of 0.1 A and a voltage step of 0.004 V, one power unit is 0.0004 W.

Samples are gathered over a window whose length is given in clock cycles. A typical length is one second of clock cycles, which spans many refreshes of about 12 ms each. When a window closes, the block presents four results: the sample count, the floor of the mean power, and the smallest and largest sample seen. It raises a one-cycle done strobe with them and then starts the next window from empty.

If the flag stays low for longer than a programmable number of cycles, a fault output rises. This covers the case where the source has stopped refreshing.

Top module: `pwr_window_averager`

## Requirements
- R1: A sample is taken only on a clock edge where `reg_valid` is 1 and was 0 at the previous edge. The codes present at that edge are used. A flag that is already high when reset is released does not count as a new sample.
- R2: While `reg_valid` stays high, further edges add no sample, even if the codes change during that time.
- R3: The power of a sample is the unsigned product `cur_code * volt_code`. At window close, `avg_pwr` is the floor of the sum of the window's samples divided by their count.
- R4: `win_done` is a one-cycle pulse every `win_len` clock cycles, with a value of 0 treated as 1. The results are held until the next pulse. A sample accepted in the closing cycle belongs to the closing window.
- R5: At window close, `min_pwr` and `max_pwr` are the smallest and largest sample power of that window.
- R6: A window with no samples reports `no_data` = 1, and `smp_count`, `avg_pwr`, `min_pwr` and `max_pwr` all equal to 0. A window with samples reports `no_data` = 0.
- R7: `fault` is 1 after more than `stall_limit` consecutive clock edges with `reg_valid` low. It returns to 0 at the first edge where `reg_valid` is high.
- R8: During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Validity flag of the refreshed codes |
| cur_code | input | CUR_W | Current code, 0.1 A per unit |
| volt_code | input | VOLT_W | Voltage code, 0.004 V per unit |
| win_len | input | WIN_W | Window length in clock cycles |
| stall_limit | input | STALL_W | Longest allowed run of invalid cycles |
| avg_pwr | output | CUR_W+VOLT_W | Floor of the mean power of the last window |
| min_pwr | output | CUR_W+VOLT_W | Smallest sample power of the last window |
| max_pwr | output | CUR_W+VOLT_W | Largest sample power of the last window |
| smp_count | output | CNT_W | Number of samples in the last window |
| win_done | output | 1 | One-cycle strobe when a window closes |
| no_data | output | 1 | Last window had no samples |
| fault | output | 1 | Flag has stayed low for longer than the limit |

## Verification
Two situations are hard to reach from the ports: codes that change in the middle of a valid stretch, and windows that are completely empty. The stimulus lines itself up on each done strobe. It then places zero to six complete refresh pulses inside the next window. During every pulse it rewrites both codes while the flag is still high, so a design that counted a second sample or latched the late codes would show a wrong count or mean. The sweep sets the sample count to 0 whenever it is a multiple of seven, which produces empty windows in between populated ones.

// File: rtl/pwr_avg_pkg.sv
package pwr_avg_pkg;
    localparam int DEF_CUR_W   = 10;
    localparam int DEF_VOLT_W  = 10;
    localparam int DEF_CNT_W   = 12;
    localparam int DEF_WIN_W   = 24;
    localparam int DEF_STALL_W = 24;
endpackage

// File: rtl/pwr_sample_capture.sv
module pwr_sample_capture #(
    parameter int CUR_W   = pwr_avg_pkg::DEF_CUR_W,
    parameter int VOLT_W  = pwr_avg_pkg::DEF_VOLT_W,
    parameter int STALL_W = pwr_avg_pkg::DEF_STALL_W,
    localparam int PW     = CUR_W + VOLT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_valid,
    input  logic [CUR_W-1:0]   cur_code,
    input  logic [VOLT_W-1:0]  volt_code,
    input  logic [STALL_W-1:0] stall_limit,
    output logic               smp_stb,
    output logic [PW-1:0]      smp_pwr,
    output logic               fault
);
    typedef struct packed {
        logic               prev;
        logic               stb;
        logic [PW-1:0]      pwr;
        logic [STALL_W-1:0] idle;
        logic               fault;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.prev = reg_valid;
        cap_d.stb  = reg_valid & ~cap_q.prev;
        if (cap_d.stb) begin
            cap_d.pwr = PW'(cur_code) * PW'(volt_code);
        end
        if (reg_valid) begin
            cap_d.idle = '0;
        end else if (cap_q.idle != '1) begin
            cap_d.idle = cap_q.idle + 1'b1;
        end
        cap_d.fault = (cap_d.idle > stall_limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q      <= '0;
            cap_q.prev <= 1'b1;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign smp_stb = cap_q.stb;
    assign smp_pwr = cap_q.pwr;
    assign fault   = cap_q.fault;

    // R1: a strobe follows an edge where the flag was high
    a_r1_flag_high: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |-> $past(reg_valid));
    // R2: two samples never come from back-to-back edges
    a_r2_single_per_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> !smp_stb);
    // R7: fault only while the flag is low
    a_r7_fault_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !$past(reg_valid));
endmodule

// File: rtl/pwr_window_stats.sv
module pwr_window_stats #(
    parameter int PW     = pwr_avg_pkg::DEF_CUR_W + pwr_avg_pkg::DEF_VOLT_W,
    parameter int CNT_W  = pwr_avg_pkg::DEF_CNT_W,
    parameter int WIN_W  = pwr_avg_pkg::DEF_WIN_W,
    localparam int SUM_W = PW + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_stb,
    input  logic [PW-1:0]    smp_pwr,
    input  logic [WIN_W-1:0] win_len,
    output logic [PW-1:0]    avg_pwr,
    output logic [PW-1:0]    min_pwr,
    output logic [PW-1:0]    max_pwr,
    output logic [CNT_W-1:0] smp_count,
    output logic             win_done,
    output logic             no_data
);
    typedef struct packed {
        logic [WIN_W-1:0] tick;
        logic [SUM_W-1:0] sum;
        logic [CNT_W-1:0] cnt;
        logic [PW-1:0]    mn;
        logic [PW-1:0]    mx;
        logic [PW-1:0]    avg;
        logic [PW-1:0]    rmin;
        logic [PW-1:0]    rmax;
        logic [CNT_W-1:0] rcnt;
        logic             done;
        logic             nodata;
    } win_t;

    win_t win_d, win_q;

    logic [SUM_W-1:0] sum_n;
    logic [CNT_W-1:0] cnt_n;
    logic [PW-1:0]    mn_n, mx_n;
    logic [SUM_W-1:0] divisor, quo;
    logic             closing;

    always_comb begin
        sum_n = win_q.sum;
        cnt_n = win_q.cnt;
        mn_n  = win_q.mn;
        mx_n  = win_q.mx;
        if (smp_stb && (win_q.cnt != '1)) begin
            sum_n = win_q.sum + SUM_W'(smp_pwr);
            cnt_n = win_q.cnt + 1'b1;
            if ((win_q.cnt == '0) || (smp_pwr < win_q.mn)) mn_n = smp_pwr;
            if ((win_q.cnt == '0) || (smp_pwr > win_q.mx)) mx_n = smp_pwr;
        end
        divisor = (cnt_n == '0) ? SUM_W'(1) : SUM_W'(cnt_n);
        quo     = sum_n / divisor;
        closing = ({1'b0, win_q.tick} + 1'b1) >= {1'b0, win_len};

        win_d      = win_q;
        win_d.done = closing;
        if (closing) begin
            win_d.tick = '0;
            win_d.sum  = '0;
            win_d.cnt  = '0;
            win_d.mn   = '0;
            win_d.mx   = '0;
            if (cnt_n == '0) begin
                win_d.avg    = '0;
                win_d.rmin   = '0;
                win_d.rmax   = '0;
                win_d.rcnt   = '0;
                win_d.nodata = 1'b1;
            end else begin
                win_d.avg    = quo[PW-1:0];
                win_d.rmin   = mn_n;
                win_d.rmax   = mx_n;
                win_d.rcnt   = cnt_n;
                win_d.nodata = 1'b0;
            end
        end else begin
            win_d.tick = win_q.tick + 1'b1;
            win_d.sum  = sum_n;
            win_d.cnt  = cnt_n;
            win_d.mn   = mn_n;
            win_d.mx   = mx_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign avg_pwr   = win_q.avg;
    assign min_pwr   = win_q.rmin;
    assign max_pwr   = win_q.rmax;
    assign smp_count = win_q.rcnt;
    assign win_done  = win_q.done;
    assign no_data   = win_q.nodata;

    // R5: extremes are ordered in a populated window
    a_r5_min_le_max: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && !no_data) |-> (min_pwr <= max_pwr));
    // R3: the mean lies between the extremes
    a_r3_avg_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && !no_data) |-> (avg_pwr >= min_pwr && avg_pwr <= max_pwr));
    // R6: empty windows report zeros
    a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && no_data) |-> (smp_count == '0 && avg_pwr == '0 && max_pwr == '0));
    // R4: results stay put between strobes
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_done && $past(rst_n)) |-> ($stable(avg_pwr) && $stable(smp_count)));
endmodule

// File: rtl/pwr_window_averager.sv
module pwr_window_averager #(
    parameter int CUR_W   = pwr_avg_pkg::DEF_CUR_W,
    parameter int VOLT_W  = pwr_avg_pkg::DEF_VOLT_W,
    parameter int CNT_W   = pwr_avg_pkg::DEF_CNT_W,
    parameter int WIN_W   = pwr_avg_pkg::DEF_WIN_W,
    parameter int STALL_W = pwr_avg_pkg::DEF_STALL_W,
    localparam int PW     = CUR_W + VOLT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_valid,
    input  logic [CUR_W-1:0]   cur_code,
    input  logic [VOLT_W-1:0]  volt_code,
    input  logic [WIN_W-1:0]   win_len,
    input  logic [STALL_W-1:0] stall_limit,
    output logic [PW-1:0]      avg_pwr,
    output logic [PW-1:0]      min_pwr,
    output logic [PW-1:0]      max_pwr,
    output logic [CNT_W-1:0]   smp_count,
    output logic               win_done,
    output logic               no_data,
    output logic               fault
);
    logic          smp_stb;
    logic [PW-1:0] smp_pwr;

    pwr_sample_capture #(
        .CUR_W(CUR_W), .VOLT_W(VOLT_W), .STALL_W(STALL_W)
    ) u_cap (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid),
        .cur_code(cur_code), .volt_code(volt_code), .stall_limit(stall_limit),
        .smp_stb(smp_stb), .smp_pwr(smp_pwr), .fault(fault)
    );

    pwr_window_stats #(
        .PW(PW), .CNT_W(CNT_W), .WIN_W(WIN_W)
    ) u_win (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_pwr(smp_pwr),
        .win_len(win_len), .avg_pwr(avg_pwr), .min_pwr(min_pwr),
        .max_pwr(max_pwr), .smp_count(smp_count), .win_done(win_done),
        .no_data(no_data)
    );
endmodule

// File: tb/sim_pwr_window_averager.sv
module sim_pwr_window_averager;
    localparam int CLK_PERIOD = 10;
    localparam int WLEN       = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_valid;
    logic [9:0]  cur_code, volt_code;
    logic [23:0] win_len, stall_limit;
    logic [19:0] avg_pwr, min_pwr, max_pwr;
    logic [11:0] smp_count;
    logic        win_done, no_data, fault;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_window_averager u0 (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid),
        .cur_code(cur_code), .volt_code(volt_code), .win_len(win_len),
        .stall_limit(stall_limit), .avg_pwr(avg_pwr), .min_pwr(min_pwr),
        .max_pwr(max_pwr), .smp_count(smp_count), .win_done(win_done),
        .no_data(no_data), .fault(fault)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_done();
        do @(negedge clk); while (win_done !== 1'b1);
    endtask

    // one refresh: invalid stretch, then valid stretch with late code changes (R2)
    task automatic put_sample(input logic [9:0] c, input logic [9:0] v);
        repeat (3) @(negedge clk);
        cur_code  = c;
        volt_code = v;
        reg_valid = 1'b1;
        repeat (2) @(negedge clk);
        cur_code  = ~c;
        volt_code = v + 10'd3;
        repeat (2) @(negedge clk);
        reg_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_valid = 1'b0; cur_code = '0; volt_code = '0;
        win_len = 24'(WLEN); stall_limit = 24'd1000;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 avg", avg_pwr, 0);
        chk("R8 min", min_pwr, 0);
        chk("R8 max", max_pwr, 0);
        chk("R8 count", smp_count, 0);
        chk("R8 done", win_done, 0);
        chk("R8 no_data", no_data, 0);
        chk("R8 fault", fault, 0);
        rst_n = 1'b1;

        wait_done();
        chk("R6 empty no_data", no_data, 1);
        chk("R6 empty count", smp_count, 0);
        // R4: pulse width and period
        begin
            int gap = 1;
            @(negedge clk);
            chk("R4 pulse width", win_done, 0);
            while (win_done !== 1'b1) begin
                @(negedge clk);
                gap++;
            end
            chk("R4 period", gap, WLEN);
        end

        for (int w = 0; w < 12; w++) begin
            int k = w % 7;
            longint sum = 0;
            longint mn = 0;
            longint mx = 0;
            for (int s = 0; s < k; s++) begin
                int c = (s * 37 + w * 113 + 5) % 1024;
                int v = (s * 53 + w * 29 + 700) % 1024;
                longint p = longint'(c) * longint'(v);
                sum += p;
                if (s == 0 || p < mn) mn = p;
                if (s == 0 || p > mx) mx = p;
                put_sample(10'(c), 10'(v));
            end
            wait_done();
            chk("R1 R2 count", smp_count, k);
            chk("R6 no_data flag", no_data, (k == 0) ? 1 : 0);
            chk("R3 average", avg_pwr, (k == 0) ? 0 : sum / k);
            chk("R5 minimum", min_pwr, mn);
            chk("R5 maximum", max_pwr, mx);
        end
        chk("R7 no fault under limit", fault, 0);

        // R7: watchdog boundary
        reg_valid = 1'b1;
        @(negedge clk);
        stall_limit = 24'd5;
        reg_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7 at limit", fault, 0);
        @(negedge clk);
        chk("R7 past limit", fault, 1);
        reg_valid = 1'b1;
        @(negedge clk);
        chk("R7 clears", fault, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule